// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block keeps the program counter of a simple sequential processor and, each cycle, looks at a six-byte window of a byte-addressed instruction store beginning at that counter. The window's first byte carries the operation class in its upper nibble and the operation variant in its lower nibble. The unit uses the operation class to work out how long the instruction is (one, two, five or six bytes). It then breaks the instruction into its fields: two register selectors and a 32-bit constant, which is assembled from the byte stream least significant byte first.

Decoding is purely combinational from the window. The counter advances by the decoded length on every rising clock edge while the unit is running. A stop instruction, or an operation class with no defined meaning, moves the unit into a terminal state that is shown on a status output. In that state the counter freezes until the next reset. The block does not choose branch targets, execute anything or touch data memory.

Top module: `ifu_top`

## Requirements
- R1: After reset the counter (`imem_addr`) is 0 and `fetch_status` is 0 (running).
- R2: `op_class` is bits 7:4 and `op_variant` is bits 3:0 of the window's first byte (`imem_win[7:0]`), for every instruction.
- R3: Classes 0x0, 0x1 and 0x9 decode to `inst_len` 1, and their register selectors are both 8 and their constant is 0.
- R4: Classes 0x2, 0x6, 0xA and 0xB decode to `inst_len` 2. `reg_a` is the high nibble and `reg_b` the low nibble of the second byte (`imem_win[15:8]`), and the constant is 0.
- R5: Classes 0x3, 0x4 and 0x5 decode to `inst_len` 6, with the selectors taken from the second byte. `const_val` is bytes 2..5 of the window, with byte 2 as the least significant byte (window 30 82 cd ab 00 00 gives reg_a 8, reg_b 2, constant 0x0000abcd).
- R6: Classes 0x7 and 0x8 decode to `inst_len` 5. `const_val` is bytes 1..4 of the window, with byte 1 as the least significant byte, and both selectors are 8.
- R7: A byte that lies past the decoded length has no effect on any decoded output.
- R8: `next_pc` equals `imem_addr` plus `inst_len`. While running on a defined class, the counter takes `next_pc` on each rising edge.
- R9: When class 0x1 (stop) is at the counter, the next edge sets `fetch_status` to 1 and loads the counter with the stop address plus one. After that, the counter and status hold.
- R10: A class above 0xB decodes with `inst_len` 1, selectors 8 and constant 0. The next edge sets `fetch_status` to 2 and leaves the counter at the offending address. After that, both hold.
- R11: A reset asserted while the unit is stopped returns it to address 0 and to the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_win | input | 48 | Six bytes read at `imem_addr`, byte k in bits 8k+7:8k |
| imem_addr | output | AW | Program counter, address of the window's first byte |
| op_class | output | 4 | Operation class nibble |
| op_variant | output | 4 | Operation variant nibble |
| reg_a | output | 4 | First register selector, 8 when the instruction has none |
| reg_b | output | 4 | Second register selector, 8 when the instruction has none |
| const_val | output | 32 | Little-endian constant, 0 when the instruction has none |
| inst_len | output | 3 | Decoded instruction length in bytes |
| next_pc | output | AW | Counter plus decoded length |
| fetch_status | output | 2 | 0 running, 1 stopped by stop instruction, 2 stopped on undefined class |

## Verification
The decoded fields, the length and `next_pc` follow the window in the same cycle. The bench therefore compares them at the falling edge that comes after the counter settles, with no extra delay. The counter and `fetch_status` change one rising edge after the instruction that drives them, so each check of a step, a stop or a freeze is made at the falling edge following that rising edge. Internally, reset release takes two rising edges before the counter may move. The reset task waits out those edges before the first falling-edge sample at address 0.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * BYTE_W;
  localparam int WIN_BYTES  = 2 + WORD_BYTES;
  localparam int WIN_W      = WIN_BYTES * BYTE_W;
  localparam int LEN_W      = 3;

  localparam logic [NIB_W-1:0] NO_REG = 4'h8;

  localparam logic [NIB_W-1:0] OP_NOP  = 4'h0;
  localparam logic [NIB_W-1:0] OP_STOP = 4'h1;
  localparam logic [NIB_W-1:0] OP_RR   = 4'h2;
  localparam logic [NIB_W-1:0] OP_IR   = 4'h3;
  localparam logic [NIB_W-1:0] OP_RM   = 4'h4;
  localparam logic [NIB_W-1:0] OP_MR   = 4'h5;
  localparam logic [NIB_W-1:0] OP_ALU  = 4'h6;
  localparam logic [NIB_W-1:0] OP_JMP  = 4'h7;
  localparam logic [NIB_W-1:0] OP_CALL = 4'h8;
  localparam logic [NIB_W-1:0] OP_RET  = 4'h9;
  localparam logic [NIB_W-1:0] OP_PUSH = 4'hA;
  localparam logic [NIB_W-1:0] OP_POP  = 4'hB;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_BAD  = 2'd2
  } fetch_st_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             has_reg;
    logic             has_const;
    logic             legal;
  } len_info_t;
endpackage

// File: rtl/ifu_rst_sync.sv
module ifu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ifu_len_decode.sv
module ifu_len_decode
  import ifu_pkg::*;
(
  input  logic [NIB_W-1:0] op_class,
  output len_info_t        info,
  output logic             is_stop
);
  always_comb begin
    info = '{len: 3'd1, has_reg: 1'b0, has_const: 1'b0, legal: 1'b1};
    unique case (op_class)
      OP_NOP, OP_STOP, OP_RET:
        info = '{len: 3'd1, has_reg: 1'b0, has_const: 1'b0, legal: 1'b1};
      OP_RR, OP_ALU, OP_PUSH, OP_POP:
        info = '{len: 3'd2, has_reg: 1'b1, has_const: 1'b0, legal: 1'b1};
      OP_IR, OP_RM, OP_MR:
        info = '{len: 3'd6, has_reg: 1'b1, has_const: 1'b1, legal: 1'b1};
      OP_JMP, OP_CALL:
        info = '{len: 3'd5, has_reg: 1'b0, has_const: 1'b1, legal: 1'b1};
      default:
        info = '{len: 3'd1, has_reg: 1'b0, has_const: 1'b0, legal: 1'b0};
    endcase
    is_stop = (op_class == OP_STOP);
  end
endmodule

// File: rtl/ifu_field_split.sv
module ifu_field_split
  import ifu_pkg::*;
(
  input  logic [WIN_W-1:0]  win,
  input  len_info_t         info,
  output logic [NIB_W-1:0]  op_class,
  output logic [NIB_W-1:0]  op_variant,
  output logic [NIB_W-1:0]  reg_a,
  output logic [NIB_W-1:0]  reg_b,
  output logic [WORD_W-1:0] const_val
);
  localparam int REG_BYTE   = 1;
  localparam int CONST_WREG = 2;
  localparam int CONST_NREG = 1;

  logic [WORD_W-1:0] const_after_reg;
  logic [WORD_W-1:0] const_no_reg;
  logic [BYTE_W-1:0] reg_byte;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_const_bytes
    assign const_after_reg[k*BYTE_W +: BYTE_W] = win[(CONST_WREG+k)*BYTE_W +: BYTE_W];
    assign const_no_reg[k*BYTE_W +: BYTE_W]    = win[(CONST_NREG+k)*BYTE_W +: BYTE_W];
  end

  assign reg_byte = win[REG_BYTE*BYTE_W +: BYTE_W];

  always_comb begin
    op_class   = win[BYTE_W-1 -: NIB_W];
    op_variant = win[NIB_W-1:0];
    reg_a      = info.has_reg ? reg_byte[BYTE_W-1 -: NIB_W] : NO_REG;
    reg_b      = info.has_reg ? reg_byte[NIB_W-1:0]         : NO_REG;
    if (!info.has_const)   const_val = '0;
    else if (info.has_reg) const_val = const_after_reg;
    else                   const_val = const_no_reg;
  end
endmodule

// File: rtl/ifu_pc_ctrl.sv
module ifu_pc_ctrl
  import ifu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [AW-1:0] next_pc,
  input  logic          legal,
  input  logic          is_stop,
  output logic [AW-1:0] pc,
  output fetch_st_e     status
);
  logic [AW-1:0] pc_d;
  fetch_st_e     st_d;
  logic          pc_en;

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc;
    st_d  = status;
    if (status == ST_RUN) begin
      if (!legal) begin
        st_d = ST_BAD;
      end else begin
        pc_en = 1'b1;
        pc_d  = next_pc;
        if (is_stop) st_d = ST_STOP;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc     <= '0;
      status <= ST_RUN;
    end else begin
      if (pc_en) pc <= pc_d;
      status <= st_d;
    end
  end
endmodule

// File: rtl/ifu_top.sv
module ifu_top
  import ifu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  imem_win,
  output logic [AW-1:0]     imem_addr,
  output logic [NIB_W-1:0]  op_class,
  output logic [NIB_W-1:0]  op_variant,
  output logic [NIB_W-1:0]  reg_a,
  output logic [NIB_W-1:0]  reg_b,
  output logic [WORD_W-1:0] const_val,
  output logic [LEN_W-1:0]  inst_len,
  output logic [AW-1:0]     next_pc,
  output logic [1:0]        fetch_status
);
  logic      srst_n;
  len_info_t info;
  logic      is_stop;
  fetch_st_e status;

  ifu_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ifu_len_decode u_len (
    .op_class (imem_win[BYTE_W-1 -: NIB_W]),
    .info     (info),
    .is_stop  (is_stop)
  );

  ifu_field_split u_split (
    .win        (imem_win),
    .info       (info),
    .op_class   (op_class),
    .op_variant (op_variant),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .const_val  (const_val)
  );

  assign inst_len = info.len;
  assign next_pc  = imem_addr + AW'(info.len);

  ifu_pc_ctrl #(.AW(AW)) u_pc (
    .clk     (clk),
    .srst_n  (srst_n),
    .next_pc (next_pc),
    .legal   (info.legal),
    .is_stop (is_stop),
    .pc      (imem_addr),
    .status  (status)
  );

  assign fetch_status = status;
endmodule

// File: rtl/ifu_chk.sv
module ifu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          srst_n,
  input logic [AW-1:0] imem_addr,
  input logic [3:0]    op_class,
  input logic [3:0]    reg_a,
  input logic [3:0]    reg_b,
  input logic [31:0]   const_val,
  input logic [2:0]    inst_len,
  input logic [AW-1:0] next_pc,
  input logic [1:0]    fetch_status
);
  p_advance_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_status == 2'd0 && op_class <= 4'hB) |=> imem_addr == $past(next_pc));

  p_stop_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_status == 2'd0 && op_class == 4'h1) |=> fetch_status == 2'd1);

  p_bad_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_status == 2'd0 && op_class > 4'hB)
      |=> (fetch_status == 2'd2 && imem_addr == $past(imem_addr)));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_status != 2'd0) |=> ($stable(imem_addr) && $stable(fetch_status)));

  p_noreg_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (op_class == 4'h7 || op_class == 4'h8) |-> (reg_a == 4'h8 && reg_b == 4'h8));

  p_noconst_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (inst_len <= 3'd2) |-> const_val == 32'd0);

  p_len_set_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (inst_len == 3'd1 || inst_len == 3'd2 || inst_len == 3'd5 || inst_len == 3'd6));
endmodule

bind ifu_top ifu_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .imem_addr    (imem_addr),
  .op_class     (op_class),
  .reg_a        (reg_a),
  .reg_b        (reg_b),
  .const_val    (const_val),
  .inst_len     (inst_len),
  .next_pc      (next_pc),
  .fetch_status (fetch_status)
);

// File: tb/ifu_top_tb.sv
module ifu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic [47:0]   imem_win;
  logic [AW-1:0] imem_addr;
  logic [3:0]    op_class, op_variant, reg_a, reg_b;
  logic [31:0]   const_val;
  logic [2:0]    inst_len;
  logic [AW-1:0] next_pc;
  logic [1:0]    fetch_status;

  logic [7:0] mem [256];
  int n_checks;
  int n_fail;

  ifu_top #(.AW(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_win     (imem_win),
    .imem_addr    (imem_addr),
    .op_class     (op_class),
    .op_variant   (op_variant),
    .reg_a        (reg_a),
    .reg_b        (reg_b),
    .const_val    (const_val),
    .inst_len     (inst_len),
    .next_pc      (next_pc),
    .fetch_status (fetch_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++)
      imem_win[8*i +: 8] = mem[8'(imem_addr[7:0] + 8'(i))];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
  endtask

  // Checks the decoded view of the instruction at the counter, then moves one cycle.
  task automatic step(input string tag, input logic [15:0] pc, input logic [3:0] cls,
                      input logic [3:0] var_, input logic [3:0] ra, input logic [3:0] rb,
                      input logic [31:0] kv, input logic [2:0] len);
    check({tag, " R8 pc"}, 32'(imem_addr), 32'(pc));
    check({tag, " R2 class"}, 32'(op_class), 32'(cls));
    check({tag, " R2 variant"}, 32'(op_variant), 32'(var_));
    check({tag, " reg_a"}, 32'(reg_a), 32'(ra));
    check({tag, " reg_b"}, 32'(reg_b), 32'(rb));
    check({tag, " const"}, const_val, kv);
    check({tag, " len"}, 32'(inst_len), 32'(len));
    check({tag, " R8 next_pc"}, 32'(next_pc), 32'(pc) + 32'(len));
    check({tag, " status run"}, 32'(fetch_status), 32'd0);
    @(negedge clk);
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic t_reset_state();
    clear_mem();
    do_reset();
    check("R1 pc after reset", 32'(imem_addr), 32'd0);
    check("R1 status after reset", 32'(fetch_status), 32'd0);
  endtask

  task automatic t_program();
    clear_mem();
    put(0, 8'h00);
    put(1, 8'h20); put(2, 8'h43);
    put(3, 8'h30); put(4, 8'h82); put(5, 8'hcd); put(6, 8'hab); put(7, 8'h00); put(8, 8'h00);
    put(9, 8'h40); put(10, 8'h64); put(11, 8'h1c); put(12, 8'h04); put(13, 8'h00); put(14, 8'h00);
    put(15, 8'h50); put(16, 8'h15); put(17, 8'hf4); put(18, 8'hff); put(19, 8'hff); put(20, 8'hff);
    put(21, 8'h61); put(22, 8'h12);
    put(23, 8'h73); put(24, 8'h44); put(25, 8'h33); put(26, 8'h22); put(27, 8'h11);
    put(28, 8'h80); put(29, 8'h78); put(30, 8'h56); put(31, 8'h34); put(32, 8'h12);
    put(33, 8'ha0); put(34, 8'h28);
    put(35, 8'hb0); put(36, 8'h38);
    put(37, 8'h90);
    put(38, 8'h10);
    put(39, 8'hee); put(40, 8'hee);
    do_reset();
    step("R3 nop",        16'd0,  4'h0, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1);
    step("R4 move",       16'd1,  4'h2, 4'h0, 4'h4, 4'h3, 32'h0, 3'd2);
    step("R5 imm",        16'd3,  4'h3, 4'h0, 4'h8, 4'h2, 32'h0000abcd, 3'd6);
    step("R5 store",      16'd9,  4'h4, 4'h0, 4'h6, 4'h4, 32'h0000041c, 3'd6);
    step("R5 load",       16'd15, 4'h5, 4'h0, 4'h1, 4'h5, 32'hfffffff4, 3'd6);
    step("R4 alu",        16'd21, 4'h6, 4'h1, 4'h1, 4'h2, 32'h0, 3'd2);
    step("R6 jump",       16'd23, 4'h7, 4'h3, 4'h8, 4'h8, 32'h11223344, 3'd5);
    step("R6 call",       16'd28, 4'h8, 4'h0, 4'h8, 4'h8, 32'h12345678, 3'd5);
    step("R4 push",       16'd33, 4'ha, 4'h0, 4'h2, 4'h8, 32'h0, 3'd2);
    step("R7 pop",        16'd35, 4'hb, 4'h0, 4'h3, 4'h8, 32'h0, 3'd2);
    step("R3 ret",        16'd37, 4'h9, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1);
    step("R3 stop",       16'd38, 4'h1, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1);
    check("R9 status stopped", 32'(fetch_status), 32'd1);
    check("R9 pc past stop", 32'(imem_addr), 32'd39);
    @(negedge clk); @(negedge clk);
    check("R9 pc frozen", 32'(imem_addr), 32'd39);
    check("R9 status held", 32'(fetch_status), 32'd1);
  endtask

  task automatic t_bad_after_nop();
    clear_mem();
    put(0, 8'h00);
    put(1, 8'hc5); put(2, 8'h12); put(3, 8'h34); put(4, 8'h56); put(5, 8'h78); put(6, 8'h9a);
    do_reset();
    step("R3 nop before bad", 16'd0, 4'h0, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1);
    check("R10 bad class", 32'(op_class), 32'hc);
    check("R10 bad reg_a", 32'(reg_a), 32'h8);
    check("R10 bad reg_b", 32'(reg_b), 32'h8);
    check("R10 bad const", const_val, 32'h0);
    check("R10 bad len", 32'(inst_len), 32'd1);
    @(negedge clk);
    check("R10 status bad", 32'(fetch_status), 32'd2);
    check("R10 pc held", 32'(imem_addr), 32'd1);
    @(negedge clk); @(negedge clk);
    check("R10 pc still held", 32'(imem_addr), 32'd1);
    check("R10 status still bad", 32'(fetch_status), 32'd2);
  endtask

  task automatic t_bad_first();
    clear_mem();
    put(0, 8'hff);
    do_reset();
    @(negedge clk);
    check("R10 class F status", 32'(fetch_status), 32'd2);
    check("R10 class F pc", 32'(imem_addr), 32'd0);
  endtask

  task automatic t_stop_first_and_rereset();
    clear_mem();
    put(0, 8'h10); put(1, 8'h30);
    do_reset();
    @(negedge clk);
    check("R9 stop at 0 status", 32'(fetch_status), 32'd1);
    check("R9 stop at 0 pc", 32'(imem_addr), 32'd1);
    do_reset();
    check("R11 pc after re-reset", 32'(imem_addr), 32'd0);
    check("R11 status after re-reset", 32'(fetch_status), 32'd0);
  endtask

  task automatic t_trailing_bytes();
    clear_mem();
    put(0, 8'h70); put(1, 8'h01); put(2, 8'h02); put(3, 8'h03); put(4, 8'h04); put(5, 8'hff);
    put(6, 8'h20); put(7, 8'h5a); put(8, 8'hff); put(9, 8'hff); put(10, 8'hff); put(11, 8'hff);
    do_reset();
    step("R7 jump trailing", 16'd0, 4'h7, 4'h0, 4'h8, 4'h8, 32'h04030201, 3'd5);
    step("R7 garbage byte 5", 16'd5, 4'hf, 4'hf, 4'h8, 4'h8, 32'h0, 3'd1);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    clear_mem();
    t_reset_state();
    t_program();
    t_bad_after_nop();
    t_bad_first();
    t_stop_first_and_rereset();
    t_trailing_bytes();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule